// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings a DDR SDRAM device from power-on to a usable state. It waits a power-up interval, then walks a fixed list of eight steps. For each step it raises a request to a separate command state machine, together with a command code, a bank select and an address word. The request stays up until that machine reports that the command went out. Once the request is released, the sequencer waits a fixed number of idle (NOP) cycles before it starts the next step. After the two mode-register loads it also waits a longer settle interval.

The step list is NOP (clock enable raised), precharge-all, load of the extended mode register, load of the normal mode register with DLL reset, precharge-all, refresh, refresh, and a final normal mode load with DLL reset clear. The final mode word selects burst length 2, sequential bursts, CAS latency 2 and normal operation. A busy flag keeps other requesters off the command machine until the last step and its padding are over. The power-up interval is set in clock cycles. By default it is derived from the clock frequency, and it can be overridden with a short value for simulation.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is asserted, `req_ext`, `cke` and `init_busy` are low. `init_busy` goes high at the first clock edge after reset is released.
- R2: The first request becomes visible exactly `PWRUP_CYCLES` clock edges after reset release, and no request is made before then.
- R3: Requests come in the order NOP, PRE, LOAD, LOAD, PRE, REF, REF, LOAD, with `req_code` encoded as 0 = NOP, 1 = precharge-all (PRE), 2 = mode-register load (LOAD), 3 = auto refresh (REF).
- R4: `cke` rises together with the first (NOP) request and stays high until the next reset.
- R5: Both precharge-all requests carry `req_addr` = 0x400 (bit 10 set, all other bits clear) and `req_bank` = 0.
- R6: The first load targets the extended mode register: `req_bank` = 2'b01 and `req_addr` = 0. The NOP and refresh requests carry bank 0 and address 0.
- R7: The second load uses `req_bank` = 0 and `req_addr` = 0x121. Bits [2:0]=001 select burst length 2, bit 3=0 selects sequential bursts, bits [6:4]=010 select CAS latency 2, bit 8=1 requests DLL reset, and all other bits are 0.
- R8: The final load uses `req_bank` = 0 and `req_addr` = 0x021, which is the R7 word with bit 8 clear.
- R9: Once raised, a request holds its code, bank and address until `cmd_done` is sampled high. It is low from the following cycle.
- R10: The next request rises exactly `PAD_CYCLES` edges after the edge at which `cmd_done` was taken. A `cmd_done` pulse while no request is up has no effect on that timing.
- R11: After the second load (the normal load with DLL reset), the gap before the next precharge-all is `PAD_CYCLES + SETTLE_CYCLES` edges.
- R12: `init_busy` stays high through the sequence. It falls `PAD_CYCLES` edges after the final load is acknowledged, and no request follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_done | input | 1 | Command machine reports the current request was issued |
| req_ext | output | 1 | Initialization request to the command machine is active |
| req_code | output | 2 | Command code of the current step |
| req_bank | output | 2 | Bank select for the current step |
| req_addr | output | ADDR_W | Address / mode word for the current step |
| cke | output | 1 | Clock enable to the memory |
| init_busy | output | 1 | Sequence in progress; other requesters locked out |

## Verification
Every result is timed by counting clock edges from an anchor. The first request is due `PWRUP_CYCLES` edges after reset release. Each later request is due `PAD_CYCLES` edges after the edge that took `cmd_done`, or `PAD_CYCLES + SETTLE_CYCLES` edges after it following the DLL-reset load. The busy flag falls `PAD_CYCLES` edges after the last acknowledgement. The bench keeps an edge counter and samples on falling clock edges. It compares the counter value at each observed change with the due edge computed from these rules. It drives `cmd_done` pulses while no request is up only when the next edge is known to fall before the due edge, and a random acknowledgement delay checks that the request is held in the meantime.

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int CLK_MHZ       = 100,
  parameter int PWRUP_US      = 200,
  parameter int PWRUP_CYCLES  = CLK_MHZ * PWRUP_US,
  parameter int SETTLE_CYCLES = 200,
  parameter int PAD_CYCLES    = 10,
  parameter int ADDR_W        = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_done,
  output logic              req_ext,
  output logic [1:0]        req_code,
  output logic [1:0]        req_bank,
  output logic [ADDR_W-1:0] req_addr,
  output logic              cke,
  output logic              init_busy
);
  localparam int CNT_MAX = (PWRUP_CYCLES > SETTLE_CYCLES) ?
                           ((PWRUP_CYCLES > PAD_CYCLES) ? PWRUP_CYCLES : PAD_CYCLES) :
                           ((SETTLE_CYCLES > PAD_CYCLES) ? SETTLE_CYCLES : PAD_CYCLES);
  localparam int CNT_W = $clog2(CNT_MAX + 1);

  localparam logic [1:0] C_NOP = 2'd0, C_PRE = 2'd1, C_LOAD = 2'd2, C_REF = 2'd3;
  localparam logic [2:0] BL_2 = 3'b001;
  localparam logic [2:0] CL_2 = 3'b010;
  localparam logic       BT_SEQ = 1'b0;
  localparam int         DLL_RST_BIT = 8;
  localparam int         AUTO_PRE_BIT = 10;
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'({CL_2, BT_SEQ, BL_2});
  localparam logic [ADDR_W-1:0] PRE_WORD  = ADDR_W'(1) << AUTO_PRE_BIT;
  localparam logic [ADDR_W-1:0] DLL_WORD  = MODE_WORD | (ADDR_W'(1) << DLL_RST_BIT);

  localparam logic [2:0] LAST_LOAD_DLL = 3'd3;
  localparam logic [2:0] LAST_STEP     = 3'd7;

  typedef enum logic [2:0] {S_PWR, S_ISSUE, S_PAD, S_SETTLE, S_DONE} state_t;

  state_t            st;
  logic [CNT_W-1:0]  cnt;
  logic [2:0]        step;

  wire pwr_end    = cnt == CNT_W'(PWRUP_CYCLES - 1);
  wire pad_end    = cnt == CNT_W'(PAD_CYCLES - 1);
  wire settle_end = cnt == CNT_W'(SETTLE_CYCLES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_PWR;
      cnt       <= '0;
      step      <= '0;
      cke       <= 1'b0;
      init_busy <= 1'b0;
    end else begin
      init_busy <= (st != S_DONE);
      case (st)
        S_PWR: begin
          if (pwr_end) begin
            st  <= S_ISSUE;
            cnt <= '0;
            cke <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_ISSUE: begin
          if (cmd_done) begin
            st  <= S_PAD;
            cnt <= '0;
          end
        end
        S_PAD: begin
          if (pad_end) begin
            cnt <= '0;
            if (step == LAST_LOAD_DLL) begin
              st   <= S_SETTLE;
              step <= step + 3'd1;
            end else if (step == LAST_STEP) begin
              st        <= S_DONE;
              init_busy <= 1'b0;
            end else begin
              st   <= S_ISSUE;
              step <= step + 3'd1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SETTLE: begin
          if (settle_end) begin
            st  <= S_ISSUE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign req_ext = (st == S_ISSUE);

  always_comb begin
    req_code = C_NOP;
    req_bank = 2'b00;
    req_addr = '0;
    case (step)
      3'd1, 3'd4: begin req_code = C_PRE; req_addr = PRE_WORD; end
      3'd2:       begin req_code = C_LOAD; req_bank = 2'b01; end
      3'd3:       begin req_code = C_LOAD; req_addr = DLL_WORD; end
      3'd5, 3'd6: req_code = C_REF;
      3'd7:       begin req_code = C_LOAD; req_addr = MODE_WORD; end
      default: ;
    endcase
  end
endmodule

module ddr_init_seq_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_done,
  input logic              req_ext,
  input logic [1:0]        req_code,
  input logic [1:0]        req_bank,
  input logic [ADDR_W-1:0] req_addr,
  input logic              cke,
  input logic              init_busy
);
  AST_NO_REQ_BEFORE_CKE: assert property (@(posedge clk) disable iff (!rst_n) !cke |-> !req_ext); // R2
  AST_CKE_STAYS:         assert property (@(posedge clk) disable iff (!rst_n) cke |=> cke); // R4
  AST_PRE_AUTO_BIT:      assert property (@(posedge clk) disable iff (!rst_n) (req_ext && req_code == 2'd1) |-> (req_addr[10] && req_bank == 2'b00)); // R5
  AST_REQ_HELD:          assert property (@(posedge clk) disable iff (!rst_n) (req_ext && !cmd_done) |=> (req_ext && $stable(req_code) && $stable(req_bank) && $stable(req_addr))); // R9
  AST_REQ_DROPS:         assert property (@(posedge clk) disable iff (!rst_n) (req_ext && cmd_done) |=> !req_ext); // R9
  AST_QUIET_WHEN_DONE:   assert property (@(posedge clk) disable iff (!rst_n) (cke && !init_busy) |-> !req_ext); // R12
endmodule

bind ddr_init_seq ddr_init_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_done(cmd_done), .req_ext(req_ext),
  .req_code(req_code), .req_bank(req_bank), .req_addr(req_addr),
  .cke(cke), .init_busy(init_busy)
);

// File: tb/test_ddr_init_seq.sv
module test_ddr_init_seq;
  localparam int PWR = 37;
  localparam int SET = 200;
  localparam int PAD = 10;
  localparam int AW  = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_done = 1'b0;
  logic          req_ext, cke, init_busy;
  logic [1:0]    req_code, req_bank;
  logic [AW-1:0] req_addr;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  ddr_init_seq #(.PWRUP_CYCLES(PWR), .SETTLE_CYCLES(SET), .PAD_CYCLES(PAD), .ADDR_W(AW)) i_ddr_init_seq (
    .clk(clk), .rst_n(rst_n), .cmd_done(cmd_done), .req_ext(req_ext),
    .req_code(req_code), .req_bank(req_bank), .req_addr(req_addr),
    .cke(cke), .init_busy(init_busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_code(input int s);
    case (s)
      0: return 0;
      1, 4: return 1;
      5, 6: return 3;
      default: return 2;
    endcase
  endfunction

  function automatic int exp_bank(input int s);
    return (s == 2) ? 1 : 0;
  endfunction

  function automatic int exp_addr(input int s);
    case (s)
      1, 4: return 'h400;
      3: return 'h121;
      7: return 'h021;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_gap(input int s);
    return (s == 4) ? PAD + SET : PAD;
  endfunction

  task automatic run_seq(input int spur_rate);
    int fall = 0;
    int rise, exp_rise, d, hc, hb, ha, guard;
    rst_n = 1'b0;
    cmd_done = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ext == 1'b0, "R1 req in reset", int'(req_ext), 0);
    chk(cke == 1'b0, "R1 cke in reset", int'(cke), 0);
    chk(init_busy == 1'b0, "R1 busy in reset", int'(init_busy), 0);
    cyc = 0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(init_busy == 1'b1, "R1 busy after release", int'(init_busy), 1);
    for (int s = 0; s < 8; s++) begin
      exp_rise = (s == 0) ? PWR : fall + exp_gap(s);
      guard = 0;
      while (!req_ext && guard < 2000) begin
        if (s == 0) chk(cke == 1'b0, "R2 cke before first request", int'(cke), 0);
        cmd_done = (cyc + 1 < exp_rise) && ($urandom_range(0, spur_rate) == 0);
        @(negedge clk);
        cmd_done = 1'b0;
        guard++;
      end
      rise = cyc;
      if (s == 0)      chk(rise == PWR, "R2 power-up wait", rise, PWR);
      else if (s == 4) chk(rise - fall == PAD + SET, "R11 settle gap", rise - fall, PAD + SET);
      else             chk(rise - fall == PAD, "R10 pad gap", rise - fall, PAD);
      chk(int'(req_code) == exp_code(s), "R3 step code", int'(req_code), exp_code(s));
      chk(int'(req_bank) == exp_bank(s), (s == 2) ? "R6 ext bank" : "R6 bank", int'(req_bank), exp_bank(s));
      if (s == 1 || s == 4)  chk(int'(req_addr) == exp_addr(s), "R5 precharge addr", int'(req_addr), exp_addr(s));
      else if (s == 3)       chk(int'(req_addr) == exp_addr(s), "R7 dll load word", int'(req_addr), exp_addr(s));
      else if (s == 7)       chk(int'(req_addr) == exp_addr(s), "R8 final mode word", int'(req_addr), exp_addr(s));
      else                   chk(int'(req_addr) == exp_addr(s), "R6 zero addr", int'(req_addr), exp_addr(s));
      chk(cke == 1'b1, "R4 cke high", int'(cke), 1);
      chk(init_busy == 1'b1, "R12 busy during sequence", int'(init_busy), 1);
      hc = int'(req_code); hb = int'(req_bank); ha = int'(req_addr);
      d = $urandom_range(0, 3);
      for (int k = 0; k < d; k++) begin
        @(negedge clk);
        chk(req_ext && int'(req_code) == hc && int'(req_bank) == hb && int'(req_addr) == ha,
            "R9 request held", int'(req_ext), 1);
      end
      cmd_done = 1'b1;
      @(negedge clk);
      cmd_done = 1'b0;
      chk(req_ext == 1'b0, "R9 request dropped", int'(req_ext), 0);
      fall = cyc;
    end
    guard = 0;
    while (init_busy && guard < 2000) begin
      cmd_done = ($urandom_range(0, spur_rate) == 0) && (cyc + 1 < fall + PAD);
      @(negedge clk);
      cmd_done = 1'b0;
      guard++;
    end
    chk(cyc - fall == PAD, "R12 busy fall time", cyc - fall, PAD);
    for (int k = 0; k < 30; k++) begin
      cmd_done = (k % 3 == 0);
      @(negedge clk);
      cmd_done = 1'b0;
      if (req_ext || init_busy || !cke) chk(1'b0, "R12 quiet after done", int'(req_ext), 0);
    end
    chk(cke == 1'b1, "R4 cke held after done", int'(cke), 1);
  endtask

  initial begin
    void'($urandom(32'd4711));
    run_seq(3);
    run_seq(0);
    run_seq(1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule